// File: doc/BRIEF.md
# Fractional Microsecond Tick Generator

This block turns a reference clock into a one-microsecond tick enable, even when the reference rate is not a whole number of megahertz (for example 12.8, 16.8, 19.2 or 38.4 MHz). Software programs a packed ratio register that holds two fields, each stored minus one. The upper field is the number of ticks to emit per window. The lower field is the window length in reference cycles. A fractional accumulator spreads the ticks evenly across each window, so the tick rate is exact over time and never drifts.

Every tick advances a free-running 32-bit microsecond counter. Software reads this counter through a simple register port, and can freeze it without disturbing the accumulator. The register port is control traffic, not a stream. There is no handshake and no back-pressure. A write is accepted on every clock edge where `reg_wr_en` is high. Read data is a combinational function of `reg_addr`.

Top module: `usec_tick_gen`

## Requirements
- R1: After reset the counter reads 0, the ratio register reads 0x0000000B, the freeze register reads 0, and no tick occurs in the first cycle.
- R2: The ratio register sits at offset 0x14. Bits [15:8] hold ticks-per-window minus one and bits [7:0] hold window-cycles minus one. Bits [31:16] are not stored and read as zero.
- R3: When the upper ratio field is zero, a tick occurs once every (lower field + 1) cycles. The first tick comes in cycle index equal to the lower field, counting from the cycle after the write.
- R4: For a fractional ratio, every window of (lower+1) consecutive cycles that starts at a ratio write holds exactly (upper+1) ticks, and no two ticks are adjacent.
- R5: The counter at offset 0x10 rises by exactly one for each tick while it is not frozen, and wraps modulo 2^32.
- R6: While bit 0 of the freeze register at offset 0x4c is set, the counter holds its value. The tick output and the accumulator phase carry on, and writing the freeze register does not move the tick phase.
- R7: A ratio write clears the accumulator. The new ratio governs ticks from the very next cycle, whatever the old phase was.
- R8: If the upper field is greater than or equal to the lower field, a tick occurs on every cycle.
- R9: Writes to the counter offset or to any unmapped offset have no effect, and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tick_o | output | 1 | One-cycle microsecond tick enable |

## Verification
A wrong accumulator remainder does not show up at once. It shows up as a tick that comes one or more cycles early or late. That error is visible within one ratio window as a wrong number of ticks, or as a first tick at the wrong cycle after a ratio write. A counter that misses or double-counts a tick shows at the next read of offset 0x10 as a gap between the counter delta and the ticks seen on `tick_o`. A freeze that leaks into the accumulator shows as a shifted tick phase on the first window after the freeze write.

// File: rtl/usec_tick_pkg.sv
package usec_tick_pkg;
  localparam int FIELD_W = 8;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RATIO  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_FREEZE = 8'h4c;

  typedef struct packed {
    logic [FIELD_W-1:0] steps_m1;
    logic [FIELD_W-1:0] span_m1;
  } ratio_cfg_t;
endpackage

// File: rtl/usec_ratio_regs.sv
module usec_ratio_regs
  import usec_tick_pkg::*;
#(
  parameter logic [2*FIELD_W-1:0] RATIO_RST = 16'h000b,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  output ratio_cfg_t        ratio_q,
  output logic              freeze_q,
  output logic              ratio_wr,
  output logic [DATA_W-1:0] rdata
);
  localparam int CFG_W = 2 * FIELD_W;

  logic freeze_wr;

  assign ratio_wr  = wr_en && (addr == OFS_RATIO);
  assign freeze_wr = wr_en && (addr == OFS_FREEZE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q  <= ratio_cfg_t'(RATIO_RST);
      freeze_q <= 1'b0;
    end else begin
      if (ratio_wr)  ratio_q  <= ratio_cfg_t'(wdata[CFG_W-1:0]);
      if (freeze_wr) freeze_q <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_COUNT:  rdata = DATA_W'(count);
      OFS_RATIO:  rdata = DATA_W'(ratio_q);
      OFS_FREEZE: rdata = DATA_W'(freeze_q);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/usec_frac_accum.sv
module usec_frac_accum
  import usec_tick_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  ratio_cfg_t ratio,
  output logic       tick
);
  localparam int NUM_W = FIELD_W + 1;
  localparam int SUM_W = NUM_W + 1;

  logic [NUM_W-1:0] acc_q;
  logic [NUM_W-1:0] step;
  logic [NUM_W-1:0] span;
  logic [SUM_W-1:0] sum;
  logic             clamp;
  logic             reach;

  assign step  = NUM_W'(ratio.steps_m1) + NUM_W'(1);
  assign span  = NUM_W'(ratio.span_m1) + NUM_W'(1);
  assign sum   = SUM_W'(acc_q) + SUM_W'(step);
  assign clamp = step >= span;
  assign reach = sum >= SUM_W'(span);
  assign tick  = clamp || reach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_q <= '0;
    else if (clear)      acc_q <= '0;
    else if (clamp)      acc_q <= '0;
    else if (reach)      acc_q <= NUM_W'(sum - SUM_W'(span));
    else                 acc_q <= NUM_W'(sum);
  end
endmodule

// File: rtl/usec_up_counter.sv
module usec_up_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             hold,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count <= '0;
    else if (inc && !hold) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/usec_tick_gen.sv
module usec_tick_gen
  import usec_tick_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [2*FIELD_W-1:0] RATIO_RST = 16'h000b
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tick_o
);
  ratio_cfg_t       ratio_q;
  logic             freeze_q;
  logic             ratio_wr;
  logic [CNT_W-1:0] count_q;

  usec_ratio_regs #(.RATIO_RST(RATIO_RST), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .count    (count_q),
    .ratio_q  (ratio_q),
    .freeze_q (freeze_q),
    .ratio_wr (ratio_wr),
    .rdata    (reg_rdata)
  );

  usec_frac_accum u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (ratio_wr),
    .ratio (ratio_q),
    .tick  (tick_o)
  );

  usec_up_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (tick_o),
    .hold  (freeze_q),
    .count (count_q)
  );
endmodule

// File: rtl/usec_tick_gen_chk.sv
module usec_tick_gen_chk
  import usec_tick_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_o,
  input logic              freeze_q,
  input logic              ratio_wr,
  input ratio_cfg_t        ratio_q,
  input logic [CNT_W-1:0]  count_q,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata
);
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !freeze_q) |=> (count_q == $past(count_q) + CNT_W'(1)));

  assert_count_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(count_q));

  assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_q |=> $stable(count_q));

  assert_clamp_every_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q.steps_m1 >= ratio_q.span_m1) |-> tick_o);

  assert_restart_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_wr |=> ((ratio_q.steps_m1 >= ratio_q.span_m1) || !tick_o));

  assert_ratio_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_RATIO) |-> (reg_rdata[DATA_W-1:2*FIELD_W] == '0));
endmodule

bind usec_tick_gen usec_tick_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_o    (tick_o),
  .freeze_q  (freeze_q),
  .ratio_wr  (ratio_wr),
  .ratio_q   (ratio_q),
  .count_q   (count_q),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata)
);

// File: tb/usec_tick_gen_bench.sv
module usec_tick_gen_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  usec_tick_gen u_usec_tick_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_o(tick_o)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run(input int n, output int ticks, output int first, output bit adj);
    bit prev = 0;
    ticks = 0; first = -1; adj = 0;
    for (int i = 0; i < n; i++) begin
      if (tick_o) begin
        if (first < 0) first = i;
        if (prev) adj = 1;
        ticks++;
      end
      prev = tick_o;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(tick_o == 1'b0, "R1 tick after reset", tick_o, 0);
    rd(8'h10, d); chk(d == 0, "R1 counter reset", d, 0);
    rd(8'h14, d); chk(d == 32'h0000000b, "R1 ratio reset", d, 32'h0b);
    rd(8'h4c, d); chk(d == 0, "R1 freeze reset", d, 0);
  endtask

  task automatic t_integer();
    int t, f; bit a; logic [31:0] c0, c1;
    wr(8'h14, 32'h0000000b);
    run(12, t, f, a);
    chk(f == 11, "R3 first tick index /12", f, 11);
    wr(8'h14, 32'h0000002f);
    run(96, t, f, a);
    chk(f == 47 && t == 2, "R3 ticks over two /48 windows", t, 2);
    rd(8'h10, c0);
    run(200, t, f, a);
    rd(8'h10, c1);
    chk(c1 - c0 == t, "R5 counter delta equals ticks", c1 - c0, t);
    chk(t == 4 || t == 5, "R3 tick count in 200 cycles /48", t, 4);
  endtask

  task automatic t_frac(input logic [15:0] cfg);
    int t, f, total = 0; bit a, anyadj = 0;
    int span = int'(cfg[7:0]) + 1;
    int steps = int'(cfg[15:8]) + 1;
    bit winok = 1;
    wr(8'h14, {16'h0, cfg});
    for (int w = 0; w < 10; w++) begin
      run(span, t, f, a);
      if (t != steps) winok = 0;
      if (a) anyadj = 1;
      total += t;
    end
    chk(winok && total == 10 * steps, "R4 ticks per window", total, 10 * steps);
    chk(!anyadj, "R4 no adjacent ticks", anyadj, 0);
  endtask

  task automatic t_restart();
    int t, f; bit a;
    wr(8'h14, 32'h0000000b);
    repeat (5) @(negedge clk);
    wr(8'h14, 32'h0000000b);
    run(12, t, f, a);
    chk(f == 11, "R7 phase restart after rewrite", f, 11);
    wr(8'h14, 32'h0000043f);
    repeat (30) @(negedge clk);
    wr(8'h14, 32'h00000007);
    run(8, t, f, a);
    chk(f == 7 && t == 1, "R7 new ratio from next cycle", f, 7);
  endtask

  task automatic t_freeze();
    int t, f; bit a; logic [31:0] c0, c1, d;
    wr(8'h14, 32'h0000000b);
    wr(8'h4c, 32'h00000001);
    rd(8'h4c, d); chk(d == 1, "R6 freeze readback", d, 1);
    rd(8'h10, c0);
    run(120, t, f, a);
    rd(8'h10, c1);
    chk(f == 10, "R6 phase kept across freeze write", f, 10);
    chk(t == 10, "R6 ticks continue while frozen", t, 10);
    chk(c1 == c0, "R6 counter held while frozen", c1, c0);
    wr(8'h4c, 32'h00000000);
    rd(8'h10, c0);
    run(48, t, f, a);
    rd(8'h10, c1);
    chk(c1 - c0 == t && t == 4, "R5 counting resumes after freeze", c1 - c0, 4);
  endtask

  task automatic t_clamp();
    int t, f; bit a; logic [31:0] c0, c1;
    wr(8'h14, 32'h00000300);
    rd(8'h10, c0);
    run(20, t, f, a);
    rd(8'h10, c1);
    chk(t == 20, "R8 clamp tick every cycle", t, 20);
    chk(c1 - c0 == 20, "R8 counter follows clamp", c1 - c0, 20);
    wr(8'h14, 32'h00000000);
    run(10, t, f, a);
    chk(t == 10, "R8 equal fields tick every cycle", t, 10);
  endtask

  task automatic t_ignored();
    logic [31:0] c0, d;
    wr(8'h4c, 32'h00000001);
    rd(8'h10, c0);
    wr(8'h10, 32'hdeadbeef);
    rd(8'h10, d); chk(d == c0, "R9 counter write ignored", d, c0);
    wr(8'h14, 32'hffff1234);
    rd(8'h14, d); chk(d == 32'h00001234, "R2 upper ratio bits read zero", d, 32'h1234);
    wr(8'h20, 32'h00000055);
    rd(8'h14, d); chk(d == 32'h00001234, "R9 unmapped write ignored", d, 32'h1234);
    rd(8'h20, d); chk(d == 0, "R9 unmapped read zero", d, 0);
    wr(8'h4c, 32'h00000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_integer();
    t_frac(16'h043f);
    t_frac(16'h0453);
    t_frac(16'h045f);
    t_frac(16'h04bf);
    t_restart();
    t_freeze();
    t_clamp();
    t_ignored();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule